// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the low-order word offset inside a four-beat burst. When a burst opens, the caller pulses `load_i` with the two lowest bits of the external address. The block then presents that start offset. On every later clock edge where the active-low step strobe `adv_n_i` is low, it moves to the next offset of the burst. The order of the offsets comes from a static mode pin.

With the mode pin low, offsets count upward and wrap modulo four. With the mode pin high, each offset is the start offset XORed with the beat index. A flag marks the fourth beat. After that beat, one more step returns the offset to the start, and the sequence runs again. Holding the strobe high freezes the offset, which gives a wait state or a suspended burst. A new load restarts the sequence at any time.

Both outputs are registered. Each reflects the inputs sampled on the most recent rising edge.

Top module: `burst_addr_seq`

## Requirements
- R1: An edge with `rst` high clears the outputs (`ofs_o` = 0, `last_o` = 0) and clears the internal start and beat index to zero. A later step from this state in linear mode gives offset 1.
- R2: An edge with `load_i` high and `rst` low makes `ofs_o` equal to `load_ofs_i` and `last_o` equal to 0 after that edge. The level of `adv_n_i` on that edge has no effect.
- R3: With `ilv_mode_i` = 0, each step makes the new `ofs_o` equal to the previous `ofs_o` plus one, modulo 4. From start 01 the sequence is 01, 10, 11, 00.
- R4: With `ilv_mode_i` = 1, the offset at beat k (k = 0..3, where beat 0 follows the load) equals the start offset XOR k. From start 01 the sequence is 01, 00, 11, 10.
- R5: A step taken while on the fourth beat returns `ofs_o` to the start offset and resets the beat index to 0, so the sequence repeats.
- R6: An edge with `adv_n_i` high and no load or reset leaves `ofs_o` and `last_o` unchanged.
- R7: `last_o` is 1 exactly when the beat index is 3, that is, after three steps since the last load or reset. It is 0 otherwise.
- R8: A load during a burst restarts the sequence at the new offset with beat index 0, whatever the beat index was.
- R9: `rst` takes priority over `load_i` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start a burst from `load_ofs_i` |
| load_ofs_i | input | 2 | Start offset (low external address bits) |
| adv_n_i | input | 1 | Step strobe, active low |
| ilv_mode_i | input | 1 | Order select: 0 linear, 1 interleaved (static) |
| ofs_o | output | 2 | Current burst offset, registered |
| last_o | output | 1 | Fourth beat of the burst, registered |

## Verification
Every result is due one edge after the stimulus that causes it. Both outputs come straight from registers that sample `rst`, `load_i`, `load_ofs_i`, `adv_n_i` and `ilv_mode_i` on the same edge.

The bench drives the inputs on the falling edge and waits for the next rising edge. It then compares the outputs one nanosecond later against a reference model, which it advances by exactly one step per edge. Random traffic changes the mode pin only on load edges, which keeps the mode static within each burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Width of the in-burst offset; a burst has 2**OFS_W beats.
  localparam int unsigned OFS_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] start_q,
  output logic [W-1:0] start_nxt
);
  always_comb begin
    start_nxt = start_q;
    if (rst)       start_nxt = '0;
    else if (load) start_nxt = load_val;
  end

  always_ff @(posedge clk) begin
    start_q <= start_nxt;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  always_comb begin
    cnt_nxt = cnt_q;
    if (rst || load) cnt_nxt = '0;
    else if (step)   cnt_nxt = cnt_q + W'(1);
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_nxt;
  end

  // R1 / R8: reset and load both restart the beat index
  a_r1_cnt_clear: assert property (@(posedge clk) (rst || load) |=> (cnt_q == '0));
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map #(
  parameter int unsigned W = 2
) (
  input  logic         order,
  input  logic [W-1:0] start,
  input  logic [W-1:0] beat,
  output logic [W-1:0] ofs
);
  logic [W-1:0] lin_ofs;
  logic [W-1:0] xor_ofs;

  // Per-bit interleave: each offset bit flips with the matching beat bit.
  for (genvar b = 0; b < int'(W); b++) begin : g_xor
    assign xor_ofs[b] = start[b] ^ beat[b];
  end

  assign lin_ofs = start + beat;
  assign ofs     = order ? xor_ofs : lin_ofs;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_ofs_i,
  input  logic         adv_n_i,
  input  logic         ilv_mode_i,
  output logic [W-1:0] ofs_o,
  output logic         last_o
);
  localparam logic [W-1:0] LAST_BEAT = {W{1'b1}};

  logic [W-1:0] start_q, start_nxt;
  logic [W-1:0] cnt_q, cnt_nxt;
  logic [W-1:0] ofs_nxt;
  logic         step;

  // A load overrides the step strobe on the same edge.
  assign step = !adv_n_i && !load_i;

  burst_start_reg #(.W(W)) u_start (
    .clk       (clk),
    .rst       (rst),
    .load      (load_i),
    .load_val  (load_ofs_i),
    .start_q   (start_q),
    .start_nxt (start_nxt)
  );

  burst_beat_cnt #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (load_i),
    .step    (step),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  burst_seq_map #(.W(W)) u_map (
    .order (ilv_mode_i),
    .start (start_nxt),
    .beat  (cnt_nxt),
    .ofs   (ofs_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_o  <= '0;
      last_o <= 1'b0;
    end else begin
      ofs_o  <= ofs_nxt;
      last_o <= (cnt_nxt == LAST_BEAT);
    end
  end

  // R1 / R9: reset wins and clears the outputs
  a_r1_reset: assert property (@(posedge clk) rst |=> (ofs_o == '0 && !last_o));

  // R2: load presents the new start offset, not the last beat
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (ofs_o == $past(load_ofs_i) && !last_o));

  // R3: linear step adds one
  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && !ilv_mode_i && $stable(ilv_mode_i))
      |=> (ofs_o == $past(ofs_o) + W'(1)));

  // R4: interleaved step flips the bits that the beat index flips
  a_r4_xor_step: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && ilv_mode_i && $stable(ilv_mode_i))
      |=> ((ofs_o ^ $past(ofs_o)) == (cnt_q ^ $past(cnt_q))));

  // R5: a step past the final beat returns to the start offset
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && last_o && $stable(ilv_mode_i))
      |=> (ofs_o == start_q && !last_o));

  // R6: strobe high holds the outputs
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i && $stable(ilv_mode_i))
      |=> ($stable(ofs_o) && $stable(last_o)));

  // R7: the flag follows the beat index
  a_r7_last: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (last_o == (cnt_q == LAST_BEAT)));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_i = 1'b0;
  logic [1:0] load_ofs_i = 2'b00;
  logic       adv_n_i = 1'b1;
  logic       ilv_mode_i = 1'b0;
  logic [1:0] ofs_o;
  logic       last_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [1:0] m_start = 2'b00;
  logic [1:0] m_beat = 2'b00;

  always #4 clk = ~clk;

  burst_addr_seq dut (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .load_ofs_i (load_ofs_i),
    .adv_n_i    (adv_n_i),
    .ilv_mode_i (ilv_mode_i),
    .ofs_o      (ofs_o),
    .last_o     (last_o)
  );

  function automatic logic [1:0] exp_ofs(input logic [1:0] s, input logic [1:0] k, input logic m);
    return m ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic check(input string tag, input logic [1:0] e_ofs, input logic e_last);
    n_chk++;
    if (ofs_o !== e_ofs || last_o !== e_last) begin
      n_fail++;
      $display("FAIL %s: ofs=%b last=%b expected ofs=%b last=%b", tag, ofs_o, last_o, e_ofs, e_last);
    end
  endtask

  // Drive one cycle at the falling edge, update the model at the rising edge, check 1 ns later.
  task automatic cyc(input logic r, input logic ld, input logic [1:0] lv,
                     input logic an, input logic m, input string tag);
    @(negedge clk);
    rst = r; load_i = ld; load_ofs_i = lv; adv_n_i = an; ilv_mode_i = m;
    @(posedge clk);
    if (r) begin m_start = 2'b00; m_beat = 2'b00; end
    else if (ld) begin m_start = lv; m_beat = 2'b00; end
    else if (!an) m_beat = m_beat + 2'd1;
    #1;
    check(tag, exp_ofs(m_start, m_beat, m), m_beat == 2'd3);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic m;
    // R1: reset state, then a linear step from start 0 gives 1
    cyc(1, 0, 2'b00, 1, 0, "R1");
    cyc(1, 0, 2'b00, 1, 0, "R1");
    cyc(0, 0, 2'b00, 0, 0, "R1");
    // R2: load with strobe low, strobe ignored
    cyc(0, 1, 2'b01, 0, 0, "R2");
    // R3 / R7: linear 01 10 11 00
    cyc(0, 0, 2'b00, 0, 0, "R3");
    cyc(0, 0, 2'b00, 0, 0, "R3");
    cyc(0, 0, 2'b00, 0, 0, "R7");
    // R5: wrap back to 01
    cyc(0, 0, 2'b00, 0, 0, "R5");
    // R4: interleaved 01 00 11 10, then wrap
    cyc(0, 1, 2'b01, 1, 1, "R2");
    cyc(0, 0, 2'b00, 0, 1, "R4");
    cyc(0, 0, 2'b00, 0, 1, "R4");
    // R6: wait states mid burst
    cyc(0, 0, 2'b00, 1, 1, "R6");
    cyc(0, 0, 2'b00, 1, 1, "R6");
    cyc(0, 0, 2'b00, 0, 1, "R7");
    cyc(0, 0, 2'b00, 1, 1, "R6");
    cyc(0, 0, 2'b00, 0, 1, "R5");
    // R8: restart mid burst
    cyc(0, 0, 2'b00, 0, 1, "R4");
    cyc(0, 1, 2'b10, 0, 1, "R8");
    cyc(0, 0, 2'b00, 0, 1, "R8");
    // R9: reset beats load
    cyc(1, 1, 2'b11, 0, 0, "R9");
    cyc(0, 0, 2'b00, 0, 0, "R9");
    // random traffic; mode moves only with a load
    void'($urandom(32'd12345));
    m = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      logic r, ld, an;
      logic [1:0] lv;
      r  = ($urandom % 100) == 0;
      ld = ($urandom % 6) == 0;
      an = ($urandom % 3) == 0;
      lv = 2'($urandom);
      if (ld || r) m = 1'($urandom);
      cyc(r, ld, lv, an, m,
          r ? "R9" : ld ? "R8" : an ? "R6" : (m ? "R4" : "R3"));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule